// File: doc/BRIEF.md
# Operate-Instruction Execution Unit

This block runs the arithmetic and logic subset of a small 16-bit instruction set: addition, bitwise AND and bitwise inversion. Each cycle it decodes the presented 16-bit instruction word and reads up to two source registers from its own bank of eight 16-bit registers. It then forms a result. When the execute strobe is high on a rising clock edge, the result lands in the destination register. On that same edge the sign flags are updated so that exactly one of negative, zero or positive is set.

Addition and AND take their second operand either from another register or from a 5-bit signed immediate carried in the instruction, and a single mode bit picks which one. Any opcode other than the three handled ones is treated as a no-op: registers and flags keep their values. A combinational debug port reads any register, so a surrounding bench or core can watch the register state.

Top module: `op_exec_top`

## Requirements
- R1: After reset, all eight registers read 0 and only the zero flag is set (flags N=0, Z=1, P=0).
- R2: Opcode 0001 (bits 15:12) with bit 5 = 0 writes reg[bits 8:6] + reg[bits 2:0] into reg[bits 11:9].
- R3: Opcode 0001 with bit 5 = 1 adds the two's-complement immediate in bits 4:0 (range -16..15), sign-extended to 16 bits, to reg[bits 8:6].
- R4: Opcode 0101 with bit 5 = 0 writes the bitwise AND of reg[bits 8:6] and reg[bits 2:0] into reg[bits 11:9].
- R5: Opcode 0101 with bit 5 = 1 writes reg[bits 8:6] AND the sign-extended immediate in bits 4:0.
- R6: Opcode 1001 writes the bitwise inverse of reg[bits 8:6] into reg[bits 11:9]. The low six bits are all ones in a well-formed word.
- R7: On every register write exactly one flag is set: N when bit 15 of the written value is 1, Z when it is 0x0000, P otherwise.
- R8: Any other opcode (for example 0000, 0010, 1101) changes no register and no flag.
- R9: While the execute strobe is low, no register or flag changes.
- R10: The register write and the flag update take effect on the same rising edge that samples the strobe high. The debug port shows the new value right after that edge.
- R11: Addition wraps modulo 2^16, with no carry or overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| exec_i | input | 1 | Execute strobe; commits the instruction on the rising edge |
| dbg_addr_i | input | 3 | Register number for the debug read |
| dbg_data_o | output | 16 | Content of the addressed register (combinational) |
| flag_n_o | output | 1 | Last written value was negative |
| flag_z_o | output | 1 | Last written value was zero |
| flag_p_o | output | 1 | Last written value was positive |

## Verification
Every result is due one edge after the strobe. The destination register and the three flags change on the rising edge that samples the strobe. The debug read is combinational, so it shows the new value within the same cycle. The bench drives a new instruction on each falling edge. A behavioural model is updated when the rising edge occurs. On the following falling edge the bench compares the flags with the model, then steps the debug address over all eight registers with sub-nanosecond delays before the next rising edge. As a result, an instruction that should have been ignored is also caught, because no register or flag may drift from the model.

// File: rtl/op_pkg.sv
package op_pkg;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned RID_W = 3;
  localparam int unsigned IMM_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_AND,
    FN_INV
  } alu_fn_e;

  typedef struct packed {
    logic             valid;
    alu_fn_e          fn;
    logic [RID_W-1:0] dst;
    logic [RID_W-1:0] src_a;
    logic [RID_W-1:0] src_b;
    logic             use_imm;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/op_decode.sv
module op_decode
  import op_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.dst     = instr_i[11:9];
    dec_o.src_a   = instr_i[8:6];
    dec_o.src_b   = instr_i[2:0];
    dec_o.use_imm = instr_i[5];
    dec_o.imm     = instr_i[IMM_W-1:0];
    dec_o.fn      = FN_ADD;
    unique case (instr_i[15:12])
      OPC_ADD: begin dec_o.valid = 1'b1; dec_o.fn = FN_ADD; end
      OPC_AND: begin dec_o.valid = 1'b1; dec_o.fn = FN_AND; end
      OPC_NOT: begin dec_o.valid = 1'b1; dec_o.fn = FN_INV; dec_o.use_imm = 1'b0; end
      default: dec_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/op_regfile.sv
module op_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned REG_N = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  input  logic [ADDR_W-1:0] raddr_d_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] rdata_d_o
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_d_o = regs_q[raddr_d_i];
endmodule

// File: rtl/op_alu.sv
module op_alu
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_fn_e           fn_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] imm_ext, opnd_b;

  assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign opnd_b  = use_imm_i ? imm_ext : b_i;

  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = a_i + opnd_b;  // wraps, carry dropped
      FN_AND:  res_o = a_i & opnd_b;
      FN_INV:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/op_ccode.sv
module op_ccode #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              n_o,
  output logic              z_o,
  output logic              p_o
);
  logic [2:0] nzp_q, nzp_d;

  always_comb begin
    if (val_i[DATA_W-1]) nzp_d = 3'b100;
    else if (val_i == '0) nzp_d = 3'b010;
    else                  nzp_d = 3'b001;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    nzp_q <= 3'b010;
    else if (upd_i) nzp_q <= nzp_d;
  end

  assign {n_o, z_o, p_o} = nzp_q;
endmodule

// File: rtl/op_exec_top.sv
module op_exec_top
  import op_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       instr_i,
  input  logic              exec_i,
  input  logic [RID_W-1:0]  dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_p_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rd_a, rd_b, wr_data;
  logic              wr_en;

  op_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign wr_en = exec_i & dec.valid;

  op_regfile #(.DATA_W(DATA_W), .ADDR_W(RID_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(dec.dst), .wdata_i(wr_data),
    .raddr_a_i(dec.src_a), .raddr_b_i(dec.src_b), .raddr_d_i(dbg_addr_i),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b), .rdata_d_o(dbg_data_o)
  );

  op_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i(dec.fn), .use_imm_i(dec.use_imm), .imm_i(dec.imm),
    .a_i(rd_a), .b_i(rd_b), .res_o(wr_data)
  );

  op_ccode #(.DATA_W(DATA_W)) u_cc (
    .clk_i, .rst_ni, .upd_i(wr_en), .val_i(wr_data),
    .n_o(flag_n_o), .z_o(flag_z_o), .p_o(flag_p_o)
  );
endmodule

// File: rtl/op_exec_chk.sv
module op_exec_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       instr_i,
  input logic              exec_i,
  input logic [DATA_W-1:0] wr_data,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_p_o
);
  logic known_op;
  assign known_op = instr_i[15:12] inside {4'b0001, 4'b0101, 4'b1001};

  // R7
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({flag_n_o, flag_z_o, flag_p_o}) == 1);

  // R7
  flag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && known_op) |=> (flag_z_o == ($past(wr_data) == '0)));

  // R7
  flag_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && known_op) |=> (flag_n_o == $past(wr_data[DATA_W-1])));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable({flag_n_o, flag_z_o, flag_p_o}));

  // R8
  unknown_op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !known_op) |=> $stable({flag_n_o, flag_z_o, flag_p_o}));
endmodule

bind op_exec_top op_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .exec_i(exec_i),
  .wr_data(wr_data), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_p_o(flag_p_o)
);

// File: tb/op_exec_top_tb_top.sv
`timescale 1ns/100ps
module op_exec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        exec = 1'b0;
  logic [2:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  logic        fn, fz, fp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] mreg [8];
  logic [2:0]  mflag;

  always #5 clk = ~clk;

  op_exec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .exec_i(exec),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data),
    .flag_n_o(fn), .flag_z_o(fz), .flag_p_o(fp)
  );

  function automatic logic [15:0] e_reg(int opc, int dr, int s1, int s2);
    return 16'((opc << 12) | (dr << 9) | (s1 << 6) | s2);
  endfunction
  function automatic logic [15:0] e_imm(int opc, int dr, int s1, int imm);
    return 16'((opc << 12) | (dr << 9) | (s1 << 6) | 32 | (imm & 31));
  endfunction
  function automatic logic [15:0] e_not(int dr, int s1);
    return 16'((9 << 12) | (dr << 9) | (s1 << 6) | 63);
  endfunction

  // behavioural reference
  task automatic model(logic [15:0] w, logic ex);
    int opc = int'(w[15:12]);
    int a = int'(mreg[w[8:6]]);
    int b;
    int r;
    if (!ex) return;
    if (w[5]) begin
      b = int'(w[4:0]);
      if (b >= 16) b -= 32;
    end else b = int'(mreg[w[2:0]]);
    case (opc)
      1: r = (a + b) % 65536;
      5: r = a & (b & 65535);
      9: r = 65535 - a;
      default: return;
    endcase
    if (r < 0) r += 65536;
    mreg[w[11:9]] = 16'(r);
    mflag = (r >= 32768) ? 3'b100 : (r == 0) ? 3'b010 : 3'b001;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, {13'd0, fn, fz, fp}, {13'd0, mflag}, "flags");
    for (int a = 0; a < 8; a++) begin
      dbg_addr = 3'(a);
      #0.4;
      check(tag, dbg_data, mreg[a], $sformatf("reg%0d", a));
    end
  endtask

  task automatic step(logic [15:0] w, logic ex, string tag);
    instr = w;
    exec  = ex;
    @(posedge clk);
    model(w, ex);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mflag = 3'b010;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(e_imm(1, 1, 0, 15), 1, "R3");       // r1 = 15, P
    step(e_imm(1, 2, 0, -16), 1, "R3");      // r2 = FFF0, N
    step(e_reg(1, 3, 1, 2), 1, "R2");        // r3 = FFFF
    step(e_imm(1, 4, 3, 1), 1, "R11");       // wrap to 0, Z
    step(e_not(5, 1), 1, "R6");              // r5 = FFF0
    step(e_reg(5, 6, 5, 3), 1, "R4");        // AND reg
    step(e_imm(5, 7, 3, 10), 1, "R5");       // AND imm positive
    step(e_imm(5, 7, 2, -8), 1, "R5");       // AND imm negative
    step(e_imm(5, 6, 1, 0), 1, "R7");        // zero result
    step(e_imm(1, 1, 1, 0), 1, "R7");        // positive, same reg
    step(e_reg(1, 2, 2, 2), 1, "R11");       // FFF0+FFF0 = FFE0
    step(e_not(0, 0), 1, "R6");              // r0 = FFFF
    step(e_imm(1, 3, 0, 1), 0, "R9");        // strobe low
    step(e_reg(0, 3, 1, 1), 1, "R8");        // opcode 0000
    step(e_reg(2, 1, 0, 0), 1, "R8");        // opcode 0010
    step(e_reg(13, 2, 0, 0), 1, "R8");       // opcode 1101
    step(e_reg(1, 3, 3, 3), 1, "R10");       // read and write same reg
    step(e_imm(1, 3, 3, 0), 1, "R10");
    for (int k = 0; k < 40; k++)
      step(e_imm((k % 3 == 0) ? 1 : 5, k % 8, (k * 3) % 8, k - 20), 1, "R2");
    for (int k = 0; k < 24; k++)
      step(e_reg((k % 2) ? 1 : 5, (k * 5) % 8, k % 8, (k + 3) % 8), 1, "R4");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule